// File: doc/BRIEF.md
# Card Contact Line Direction Bridge

This block joins a set of open-drain line pairs between a smart-card contact side and a host side: the data contact and two auxiliary contacts, each with a partner line on the host side. Each wire is taken to be pulled up. The block never drives a line high. It only asserts a pull-low enable for one side of a pair. The direction of each pair is not fixed. The side that pulls its line low first becomes the source. The block then holds the other side low until the source line rises again, and after that both lines are released.

Each line is sampled through a two-flop synchronizer before edge detection. A per-pair arbiter records the current direction. Two inputs gate the block. A bridge-enable bit allows forwarding. A reception flag comes from the session sequencer. While that flag is low, every contact-side line is held low, which is the state of the contacts outside a card session.

Top module: `card_io_bridge`

## Requirements
- R1: After reset with the reception flag low, `card_pull_low_o` is all ones and `host_pull_low_o` is all zeros.
- R2: While `rx_on_i` is 0, every bit of `card_pull_low_o` is 1 and every bit of `host_pull_low_o` is 0, whatever the line levels and the enable bit.
- R3: While `rx_on_i` is 1 and `bridge_en_i` is 0, no line of any pair is pulled low, even when one side of a pair falls.
- R4: With the bridge active, a falling edge on the contact line of a neutral pair makes that pair pull its host line low. The output appears after the third rising clock edge that follows the input change.
- R5: With the bridge active, a falling edge on the host line of a neutral pair makes that pair pull its contact line low, with the same three-edge latency.
- R6: A rising edge on the source line of a locked pair returns that pair to neutral three clock edges after the change, so neither side is pulled low any more.
- R7: If both lines of a neutral pair fall in the same clock cycle, the contact line becomes the source and the host line is pulled low.
- R8: While a pair is locked, edges on its driven line have no effect: the direction stays the same. Once the pair is released, the driven line rising does not start a new transfer.
- R9: Clearing `bridge_en_i` or `rx_on_i` during a transfer removes the pull-low on the following side in the same cycle. The pair is left neutral, so setting the bit again does not resume the transfer.
- R10: Each pair arbitrates on its own. Locking one pair never changes the outputs of another pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bridge_en_i | input | 1 | Allows forwarding between the two sides |
| rx_on_i | input | 1 | Reception flag from the session sequencer; contact lines are held low while it is 0 |
| card_line_i | input | NUM_PAIRS | Sampled levels of the contact-side lines (bit 0 data, 1 and 2 auxiliary) |
| host_line_i | input | NUM_PAIRS | Sampled levels of the host-side lines, same bit order |
| card_pull_low_o | output | NUM_PAIRS | Pull-low enable per contact-side line |
| host_pull_low_o | output | NUM_PAIRS | Pull-low enable per host-side line |

## Verification
The bench targets the echo hazard. Once the host line is pulled low, its own falling edge reaches the synchronizer a few cycles later, and the same happens with its rising edge after release. A design that did not ignore these edges would reverse the pair or lock it again on its own output. The bench also drops both lines of a pair in the same cycle. A design with the priority reversed would pull the contact line low instead of the host line. Two further cases are aborting a transfer through the enable bit and through the reception flag. A design that only cleared the drive on the next edge, or that kept the stored direction, would hold a line low or resume the transfer when the bit returns.

// File: rtl/card_io_bridge_pkg.sv
package card_io_bridge_pkg;
    typedef enum logic [1:0] {
        DIR_NEUTRAL = 2'b00,
        DIR_CARD_SRC = 2'b01,
        DIR_HOST_SRC = 2'b10
    } dir_e;
endpackage

// File: rtl/bridge_line_sync.sv
module bridge_line_sync #(
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic fell_o,
    output logic rose_o
);
    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.meta = line_i;
        s_d.stable = s_q.meta;
        s_d.prev = s_q.stable;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{meta: RESET_LEVEL, stable: RESET_LEVEL, prev: RESET_LEVEL};
        else s_q <= s_d;
    end

    assign fell_o = s_q.prev & ~s_q.stable;
    assign rose_o = ~s_q.prev & s_q.stable;
endmodule

// File: rtl/bridge_pair_arbiter.sv
module bridge_pair_arbiter
    import card_io_bridge_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic card_fell_i,
    input  logic card_rose_i,
    input  logic host_fell_i,
    input  logic host_rose_i,
    output dir_e dir_o
);
    typedef struct packed {
        dir_e dir;
    } arb_t;

    arb_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (!active_i) begin
            a_d.dir = DIR_NEUTRAL;
        end else begin
            unique case (a_q.dir)
                DIR_NEUTRAL: begin
                    if (card_fell_i) a_d.dir = DIR_CARD_SRC;
                    else if (host_fell_i) a_d.dir = DIR_HOST_SRC;
                end
                DIR_CARD_SRC: if (card_rose_i) a_d.dir = DIR_NEUTRAL;
                DIR_HOST_SRC: if (host_rose_i) a_d.dir = DIR_NEUTRAL;
                default: a_d.dir = DIR_NEUTRAL;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) a_q <= '{dir: DIR_NEUTRAL};
        else a_q <= a_d;
    end

    assign dir_o = a_q.dir;
endmodule

// File: rtl/card_io_bridge.sv
module card_io_bridge
    import card_io_bridge_pkg::*;
#(
    parameter int NUM_PAIRS = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 bridge_en_i,
    input  logic                 rx_on_i,
    input  logic [NUM_PAIRS-1:0] card_line_i,
    input  logic [NUM_PAIRS-1:0] host_line_i,
    output logic [NUM_PAIRS-1:0] card_pull_low_o,
    output logic [NUM_PAIRS-1:0] host_pull_low_o
);
    logic active;
    assign active = bridge_en_i & rx_on_i;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        logic card_fell, card_rose, host_fell, host_rose;
        dir_e dir;

        // contact lines sit low outside a session, host lines sit high
        bridge_line_sync #(.RESET_LEVEL(1'b0)) i_card_sync (
            .clk_i(clk_i), .rst_ni(rst_ni), .line_i(card_line_i[p]),
            .fell_o(card_fell), .rose_o(card_rose)
        );
        bridge_line_sync #(.RESET_LEVEL(1'b1)) i_host_sync (
            .clk_i(clk_i), .rst_ni(rst_ni), .line_i(host_line_i[p]),
            .fell_o(host_fell), .rose_o(host_rose)
        );
        bridge_pair_arbiter i_arb (
            .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active),
            .card_fell_i(card_fell), .card_rose_i(card_rose),
            .host_fell_i(host_fell), .host_rose_i(host_rose),
            .dir_o(dir)
        );

        assign host_pull_low_o[p] = active & (dir == DIR_CARD_SRC);
        assign card_pull_low_o[p] = ~rx_on_i | (active & (dir == DIR_HOST_SRC));
    end
endmodule

// File: rtl/card_io_bridge_checker.sv
module card_io_bridge_checker #(
    parameter int NUM_PAIRS = 3
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 bridge_en_i,
    input logic                 rx_on_i,
    input logic [NUM_PAIRS-1:0] card_line_i,
    input logic [NUM_PAIRS-1:0] host_line_i,
    input logic [NUM_PAIRS-1:0] card_pull_low_o,
    input logic [NUM_PAIRS-1:0] host_pull_low_o
);
    a_r2_contacts_held_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_on_i |-> (&card_pull_low_o) && (host_pull_low_o == '0));

    a_r3_quiet_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_on_i && !bridge_en_i) |-> (card_pull_low_o == '0) && (host_pull_low_o == '0));

    a_r10_one_side_per_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_on_i |-> ((card_pull_low_o & host_pull_low_o) == '0));

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
        a_r4_host_drive_follows_card_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(host_pull_low_o[p]) |-> $past(card_line_i[p], 3) == 1'b0);

        a_r5_card_drive_follows_host_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rx_on_i && $past(rx_on_i) && $rose(card_pull_low_o[p])) |-> $past(host_line_i[p], 3) == 1'b0);

        a_r6_release_on_source_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($fell(host_pull_low_o[p]) && bridge_en_i && rx_on_i) |-> $past(card_line_i[p], 3) == 1'b1);
    end
endmodule

bind card_io_bridge card_io_bridge_checker #(.NUM_PAIRS(NUM_PAIRS)) i_card_io_bridge_checker (
    .clk_i(clk_i), .rst_ni(rst_ni), .bridge_en_i(bridge_en_i), .rx_on_i(rx_on_i),
    .card_line_i(card_line_i), .host_line_i(host_line_i),
    .card_pull_low_o(card_pull_low_o), .host_pull_low_o(host_pull_low_o)
);

// File: tb/test_card_io_bridge.sv
module test_card_io_bridge;
    localparam int N = 3;
    localparam int MAX_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic rx = 1'b0;
    logic [N-1:0] card_ext = '0;
    logic [N-1:0] host_ext = '0;
    logic [N-1:0] card_pl, host_pl;
    logic [N-1:0] card_line, host_line;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // pulled-up wires: low when either party pulls
    assign card_line = ~(card_ext | card_pl);
    assign host_line = ~(host_ext | host_pl);

    card_io_bridge #(.NUM_PAIRS(N)) i_card_io_bridge (
        .clk_i(clk), .rst_ni(rst_n), .bridge_en_i(en), .rx_on_i(rx),
        .card_line_i(card_line), .host_line_i(host_line),
        .card_pull_low_o(card_pl), .host_pull_low_o(host_pl)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_drv(input string req, input logic [N-1:0] exp_card, input logic [N-1:0] exp_host);
        checks++;
        if (card_pl !== exp_card || host_pl !== exp_host) begin
            errors++;
            $display("FAIL %s: card=%b host=%b expected card=%b host=%b", req, card_pl, host_pl, exp_card, exp_host);
        end
    endtask

    task automatic t_reset();
        expect_drv("R1 reset state", 3'b111, 3'b000);
    endtask

    task automatic t_outside_session();
        en = 1'b1;
        host_ext[0] = 1'b1;
        step(5);
        expect_drv("R2 held outside session", 3'b111, 3'b000);
        host_ext[0] = 1'b0;
        step(5);
    endtask

    task automatic t_disabled();
        en = 1'b0;
        rx = 1'b1;
        step(4);
        card_ext[1] = 1'b1;
        step(5);
        expect_drv("R3 disabled bridge", 3'b000, 3'b000);
        card_ext[1] = 1'b0;
        step(5);
    endtask

    task automatic t_card_source();
        en = 1'b1;
        step(1);
        card_ext[0] = 1'b1;
        step(2);
        expect_drv("R4 not before third edge", 3'b000, 3'b000);
        step(1);
        expect_drv("R4 host follows card", 3'b000, 3'b001);
        card_ext[0] = 1'b0;
        step(2);
        expect_drv("R6 still held before third edge", 3'b000, 3'b001);
        step(1);
        expect_drv("R6 release on card rise", 3'b000, 3'b000);
        step(5);
    endtask

    task automatic t_host_source();
        host_ext[1] = 1'b1;
        step(3);
        expect_drv("R5 card follows host", 3'b010, 3'b000);
        host_ext[1] = 1'b0;
        step(3);
        expect_drv("R6 release on host rise", 3'b000, 3'b000);
        step(5);
        expect_drv("R8 no relock after release", 3'b000, 3'b000);
    endtask

    task automatic t_simultaneous();
        card_ext[2] = 1'b1;
        host_ext[2] = 1'b1;
        step(3);
        expect_drv("R7 tie goes to contact side", 3'b000, 3'b100);
        host_ext[2] = 1'b0;
        step(5);
        expect_drv("R8 host release ignored while locked", 3'b000, 3'b100);
        card_ext[2] = 1'b0;
        step(3);
        expect_drv("R6 tie pair release", 3'b000, 3'b000);
        step(5);
    endtask

    task automatic t_echo();
        card_ext[0] = 1'b1;
        step(8);
        expect_drv("R8 own echo ignored", 3'b000, 3'b001);
        card_ext[0] = 1'b0;
        step(3);
        expect_drv("R6 echo pair release", 3'b000, 3'b000);
        step(6);
        expect_drv("R8 echo rise ignored", 3'b000, 3'b000);
    endtask

    task automatic t_independent();
        card_ext[0] = 1'b1;
        step(3);
        host_ext[1] = 1'b1;
        step(3);
        expect_drv("R10 pairs independent", 3'b010, 3'b001);
        card_ext[0] = 1'b0;
        step(3);
        expect_drv("R10 pair1 kept after pair0 release", 3'b010, 3'b000);
        host_ext[1] = 1'b0;
        step(3);
        expect_drv("R10 both released", 3'b000, 3'b000);
        step(5);
    endtask

    task automatic t_abort();
        card_ext[2] = 1'b1;
        step(3);
        expect_drv("R4 lock before abort", 3'b000, 3'b100);
        en = 1'b0;
        #1;
        expect_drv("R9 enable abort same cycle", 3'b000, 3'b000);
        step(2);
        en = 1'b1;
        step(4);
        expect_drv("R9 no resume after enable", 3'b000, 3'b000);
        card_ext[2] = 1'b0;
        step(5);
        card_ext[0] = 1'b1;
        step(3);
        rx = 1'b0;
        #1;
        expect_drv("R9 reception abort same cycle", 3'b111, 3'b000);
        step(2);
        card_ext[0] = 1'b0;
        rx = 1'b1;
        step(6);
        expect_drv("R9 neutral after reception returns", 3'b000, 3'b000);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_outside_session();
        t_disabled();
        t_card_source();
        t_host_source();
        t_simultaneous();
        t_echo();
        t_independent();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule